// File: doc/BRIEF.md
# CAN Mailbox Filter and Transmit Arbiter

This block manages the message mailboxes of a CAN 2.0B controller. A protocol engine, which sits outside the block, hands over each frame it has fully received. The block compares the frame against sixteen mailboxes. Each mailbox is set up for receive, set up for transmit, or left inactive. A receive mailbox takes a frame when the frame's identifier agrees with the mailbox identifier on every bit that the applicable acceptance mask selects. Mailboxes 0 to 13 share one global mask, and mailboxes 14 and 15 each have a mask of their own. An accepted frame is stored together with the value of a free-running 16-bit timer.

On the transmit side, the block offers one pending mailbox at a time to the protocol engine. The rule for choosing it is selectable: the lowest identifier, or the lowest mailbox index. When the engine acknowledges the offer, the mailbox is retired and stamped with the timer value. A listen-only mode stops all transmit offers.

Software sees mailboxes, masks, the mode and the timer through a simple register port. Reads are combinational. Writes and read side effects take place at the clock edge.

Top module: `can_mbox_mgr`

## Requirements
- R1: After reset, every mailbox control word reads 0 (inactive). All three masks read 0x1FFFFFFF, the mode reads 0, `tx_req` is low and the timer starts from 0.
- R2: A frame matches a mailbox only if the two conditions below both hold.
  - The IDE bits are equal.
  - The identifiers are equal on every bit where the mask has a 1. A mask bit of 0 means don't care. Standard identifiers sit in bits 28:18, and for a standard frame only those bits are compared.
- R3: Mailboxes 0 to 13 use the global mask (address 0x80). Mailbox 14 uses mask A (0x81) and mailbox 15 uses mask B (0x82).
- R4: A frame goes to the lowest-index matching mailbox whose state is RX-empty (code 1). That mailbox becomes RX-full (code 2) and stores the identifier, the IDE bit, the length code and the data.
- R5: A frame that matches no empty mailbox is discarded. The overrun bit (bit 3 of the control word) is then set on the lowest-index matching RX-full mailbox. A software write to the control word clears the overrun bit.
- R6: The timer increments every cycle and reads at 0x84. An accepted frame stores the timer value of its `rx_valid` cycle in word 4 of its mailbox.
- R7: With mode bit 1 set, `tx_mb` is the lowest-index mailbox in TX-pending state (code 4).
- R8: With mode bit 1 clear, `tx_mb` is the TX-pending mailbox with the smallest 29-bit identifier field, where standard identifiers are top-aligned. A tie goes to the lower index.
- R9: `tx_ack` while `tx_req` is high moves the offered mailbox to TX-done (code 3) and stores the timer value in its word 4.
- R10: With mode bit 0 (listen-only) set, `tx_req` stays low and `tx_ack` changes nothing.
- R11: Reading a mailbox control word locks that mailbox. A locked mailbox neither takes a frame nor gets an overrun. The lock stays until the timer register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (triggers lock/unlock) |
| cfg_addr | input | 8 | Register address. Bit 7 = 0: mailbox `addr[6:3]`, word `addr[2:0]` (0 control, 1 identifier, 2 data bytes 0-3, 3 data bytes 4-7, 4 time stamp). Bit 7 = 1: word 0 global mask, 1 mask A, 2 mask B, 3 mode, 4 timer |
| cfg_wdata | input | 32 | Write data. Control word: bits 2:0 code, bit 3 overrun, bit 4 IDE, bits 11:8 length code |
| cfg_rdata | output | 32 | Combinational read data |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| rx_id | input | 29 | Received identifier (standard frames in bits 28:18) |
| rx_ide | input | 1 | Received frame is extended |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data, byte 0 in bits 7:0 |
| tx_req | output | 1 | A mailbox is offered for transmission |
| tx_mb | output | 4 | Index of the offered mailbox |
| tx_id | output | 29 | Identifier of the offered mailbox |
| tx_ide | output | 1 | IDE bit of the offered mailbox |
| tx_dlc | output | 4 | Length code of the offered mailbox |
| tx_data | output | 64 | Data of the offered mailbox |
| tx_ack | input | 1 | The offered frame was sent |

## Verification
The assertions check the transmit side on every cycle. They check that an offer always names a pending mailbox and never happens in listen-only mode, that index priority never passes over a lower pending mailbox, and that an acknowledged mailbox leaves the pending state. They also check that the timer steps by one and that the number of full mailboxes grows by at most one, and only on a frame strobe. Only the bench's scenarios can show the rest:
- mask selection per mailbox, the IDE rule and the standard-identifier field;
- where overruns land, the stored contents and stamps;
- identifier ordering with ties;
- the read-triggered lock.

// File: rtl/can_mbox_mgr.sv
module can_mbox_mgr #(
  parameter int NMB = 16,
  parameter int IDW = 29,
  parameter int TSW = 16,
  parameter int AW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_re,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   rx_valid,
  input  logic [IDW-1:0]         rx_id,
  input  logic                   rx_ide,
  input  logic [3:0]             rx_dlc,
  input  logic [63:0]            rx_data,
  output logic                   tx_req,
  output logic [$clog2(NMB)-1:0] tx_mb,
  output logic [IDW-1:0]         tx_id,
  output logic                   tx_ide,
  output logic [3:0]             tx_dlc,
  output logic [63:0]            tx_data,
  input  logic                   tx_ack
);
  localparam int MBW = $clog2(NMB);
  localparam logic [2:0] C_OFF = 3'd0, C_RXE = 3'd1, C_RXF = 3'd2, C_TXD = 3'd3, C_TXP = 3'd4;
  localparam logic [IDW-1:0] STD_BITS = {11'h7FF, {(IDW-11){1'b0}}};

  logic [2:0]     code_q [NMB];
  logic [3:0]     dlc_q  [NMB];
  logic [IDW-1:0] id_q   [NMB];
  logic [63:0]    data_q [NMB];
  logic [TSW-1:0] ts_q   [NMB];
  logic [NMB-1:0] ovr_q, ide_q;
  logic [IDW-1:0] gmask, mask_a, mask_b;
  logic [1:0]     mode;
  logic [TSW-1:0] timer;
  logic           lock_vld;
  logic [MBW-1:0] lock_mb;

  wire            glob = cfg_addr[AW-1];
  wire [MBW-1:0]  amb  = cfg_addr[MBW+2:3];
  wire [2:0]      word = cfg_addr[2:0];
  wire            listen   = mode[0];
  wire            by_index = mode[1];
  wire            unused_bits = ^{cfg_wdata[31:IDW], cfg_wdata[31:12], cfg_wdata[7:5]};

  logic [NMB-1:0] pend, full_v, empty_v, hit;
  logic           acc_ok, ovr_ok, best_ok;
  logic [MBW-1:0] acc_mb, ovr_mb, best_mb;
  logic [IDW-1:0] best_id, eff;

  always_comb begin
    for (int i = 0; i < NMB; i++) begin
      pend[i]    = code_q[i] == C_TXP;
      full_v[i]  = code_q[i] == C_RXF;
      empty_v[i] = code_q[i] == C_RXE;
      eff = (i == NMB-1) ? mask_b : (i == NMB-2) ? mask_a : gmask;
      if (!rx_ide) eff = eff & STD_BITS;
      hit[i] = (empty_v[i] || full_v[i]) && (ide_q[i] == rx_ide) &&
               (((id_q[i] ^ rx_id) & eff) == '0) &&
               !(lock_vld && lock_mb == MBW'(i));
    end
    acc_ok = 1'b0; acc_mb = '0; ovr_ok = 1'b0; ovr_mb = '0;
    for (int i = NMB-1; i >= 0; i--) begin
      if (hit[i] && empty_v[i]) begin acc_ok = 1'b1; acc_mb = MBW'(i); end
      if (hit[i] && full_v[i])  begin ovr_ok = 1'b1; ovr_mb = MBW'(i); end
    end
    best_ok = 1'b0; best_mb = '0; best_id = '0;
    for (int i = 0; i < NMB; i++) begin
      if (pend[i] && (!best_ok || (!by_index && id_q[i] < best_id))) begin
        best_ok = 1'b1; best_mb = MBW'(i); best_id = id_q[i];
      end
    end
  end

  assign tx_req  = best_ok && !listen;
  assign tx_mb   = best_mb;
  assign tx_id   = id_q[best_mb];
  assign tx_ide  = ide_q[best_mb];
  assign tx_dlc  = dlc_q[best_mb];
  assign tx_data = data_q[best_mb];

  always_comb begin
    cfg_rdata = '0;
    if (glob) begin
      case (word)
        3'd0: cfg_rdata = 32'(gmask);
        3'd1: cfg_rdata = 32'(mask_a);
        3'd2: cfg_rdata = 32'(mask_b);
        3'd3: cfg_rdata = 32'(mode);
        3'd4: cfg_rdata = 32'(timer);
        default: cfg_rdata = '0;
      endcase
    end else begin
      case (word)
        3'd0: cfg_rdata = {20'd0, dlc_q[amb], 3'd0, ide_q[amb], ovr_q[amb], code_q[amb]};
        3'd1: cfg_rdata = 32'(id_q[amb]);
        3'd2: cfg_rdata = data_q[amb][31:0];
        3'd3: cfg_rdata = data_q[amb][63:32];
        3'd4: cfg_rdata = 32'(ts_q[amb]);
        default: cfg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMB; i++) begin
        code_q[i] <= C_OFF; dlc_q[i] <= '0; id_q[i] <= '0; data_q[i] <= '0; ts_q[i] <= '0;
      end
      ovr_q <= '0; ide_q <= '0;
      gmask <= '1; mask_a <= '1; mask_b <= '1;
      mode <= '0; timer <= '0; lock_vld <= 1'b0; lock_mb <= '0;
    end else begin
      timer <= timer + TSW'(1);
      if (cfg_re && !glob && word == 3'd0) begin lock_vld <= 1'b1; lock_mb <= amb; end
      if (cfg_re && glob && word == 3'd4) lock_vld <= 1'b0;
      if (rx_valid) begin
        if (acc_ok) begin
          code_q[acc_mb] <= C_RXF; id_q[acc_mb] <= rx_id; ide_q[acc_mb] <= rx_ide;
          dlc_q[acc_mb] <= rx_dlc; data_q[acc_mb] <= rx_data; ts_q[acc_mb] <= timer;
          ovr_q[acc_mb] <= 1'b0;
        end else if (ovr_ok) begin
          ovr_q[ovr_mb] <= 1'b1;
        end
      end
      if (tx_req && tx_ack) begin
        code_q[best_mb] <= C_TXD; ts_q[best_mb] <= timer;
      end
      if (cfg_we) begin
        if (glob) begin
          case (word)
            3'd0: gmask  <= cfg_wdata[IDW-1:0];
            3'd1: mask_a <= cfg_wdata[IDW-1:0];
            3'd2: mask_b <= cfg_wdata[IDW-1:0];
            3'd3: mode   <= cfg_wdata[1:0];
            default: ;
          endcase
        end else begin
          case (word)
            3'd0: begin
              code_q[amb] <= cfg_wdata[2:0]; ovr_q[amb] <= 1'b0;
              ide_q[amb] <= cfg_wdata[4]; dlc_q[amb] <= cfg_wdata[11:8];
            end
            3'd1: id_q[amb] <= cfg_wdata[IDW-1:0];
            3'd2: data_q[amb][31:0]  <= cfg_wdata;
            3'd3: data_q[amb][63:32] <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_mbox_mgr_chk.sv
module can_mbox_mgr_chk #(
  parameter int NMB = 16,
  parameter int TSW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tx_req,
  input logic                   tx_ack,
  input logic [$clog2(NMB)-1:0] tx_mb,
  input logic                   cfg_we,
  input logic                   rx_valid,
  input logic [NMB-1:0]         pend,
  input logic [NMB-1:0]         full_v,
  input logic                   listen,
  input logic                   by_index,
  input logic [TSW-1:0]         timer
);
  logic [NMB-1:0] below;
  assign below = pend & ((NMB'(1) << tx_mb) - NMB'(1));

  p_listen_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) listen |-> !tx_req);
  p_offer_pending_r7: assert property (@(posedge clk) disable iff (!rst_n) tx_req |-> pend[tx_mb]);
  p_index_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && by_index) |-> (below == '0));
  p_ack_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ack && !cfg_we) |=> !pend[$past(tx_mb)]);
  p_timer_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (timer == $past(timer) + TSW'(1)));
  p_single_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_we) |=> ($countones(full_v) <= $countones($past(full_v)) + 1));
  p_no_stray_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !cfg_we) |=> ($countones(full_v) <= $countones($past(full_v))));
endmodule

bind can_mbox_mgr can_mbox_mgr_chk #(.NMB(NMB), .TSW(TSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_ack(tx_ack), .tx_mb(tx_mb),
  .cfg_we(cfg_we), .rx_valid(rx_valid), .pend(pend), .full_v(full_v),
  .listen(listen), .by_index(by_index), .timer(timer)
);

// File: tb/can_mbox_mgr_tb_top.sv
module can_mbox_mgr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_re = 0, rx_valid = 0, rx_ide = 0, tx_ack = 0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [28:0] rx_id = '0, tx_id;
  logic [3:0] rx_dlc = '0, tx_dlc, tx_mb;
  logic [63:0] rx_data = '0, tx_data;
  logic tx_req, tx_ide;
  logic [15:0] cyc, ets;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= '0; else cyc <= cyc + 16'd1;

  can_mbox_mgr dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .tx_req(tx_req), .tx_mb(tx_mb), .tx_id(tx_id), .tx_ide(tx_ide), .tx_dlc(tx_dlc),
    .tx_data(tx_data), .tx_ack(tx_ack));

  function automatic logic [7:0] ma(input int mb, input int w);
    return {1'b0, 4'(mb), 3'(w)};
  endfunction
  function automatic logic [31:0] cw(input int code, input bit ide, input int dlc);
    return {20'd0, 4'(dlc), 3'd0, ide, 1'b0, 3'(code)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(posedge clk); #1 cfg_we = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; cfg_re = 1; #1 d = cfg_rdata;
    @(posedge clk); #1 cfg_re = 0;
  endtask
  task automatic rdc(input int mb, output logic [31:0] d);
    logic [31:0] x;
    rd(ma(mb, 0), d); rd(8'h84, x);
  endtask
  task automatic send(input logic [28:0] id, input bit ide, input logic [3:0] dlc, input logic [63:0] dat);
    @(negedge clk); rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = dat; rx_valid = 1; ets = cyc;
    @(posedge clk); #1 rx_valid = 0;
  endtask
  task automatic ack();
    @(negedge clk); tx_ack = 1; ets = cyc;
    @(posedge clk); #1 tx_ack = 0;
  endtask
  task automatic setmb(input int mb, input int code, input bit ide, input logic [28:0] id);
    wr(ma(mb, 1), 32'(id)); wr(ma(mb, 0), cw(code, ide, 8));
  endtask
  task automatic clear_all();
    for (int i = 0; i < 16; i++) wr(ma(i, 0), 32'd0);
    wr(8'h80, 32'h1FFFFFFF); wr(8'h81, 32'h1FFFFFFF); wr(8'h82, 32'h1FFFFFFF); wr(8'h83, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [15:0] c0;
    rdc(0, d);  chk("R1 ctrl mb0", d, 0);
    rdc(15, d); chk("R1 ctrl mb15", d, 0);
    rd(8'h80, d); chk("R1 global mask", d, 32'h1FFFFFFF);
    rd(8'h82, d); chk("R1 mask B", d, 32'h1FFFFFFF);
    rd(8'h83, d); chk("R1 mode", d, 0);
    chk("R1 tx_req", tx_req, 0);
    @(negedge clk); cfg_addr = 8'h84; #1 c0 = cyc; chk("R6 timer read", cfg_rdata, 32'(c0));
    repeat (5) @(negedge clk); #1 chk("R6 timer advance", cfg_rdata, 32'(c0 + 16'd5));
  endtask

  task automatic t_accept();
    logic [31:0] d; logic [15:0] e1;
    setmb(0, 1, 1, 29'h1234567); setmb(1, 1, 1, 29'h1234567);
    send(29'h1234567, 1, 4'd5, 64'h1122334455667788); e1 = ets;
    rdc(0, d); chk("R4 mb0 full", d, cw(2, 1, 5));
    rd(ma(0, 1), d); chk("R4 mb0 id", d, 32'h1234567);
    rd(ma(0, 2), d); chk("R4 mb0 data lo", d, 32'h55667788);
    rd(ma(0, 3), d); chk("R4 mb0 data hi", d, 32'h11223344);
    rd(ma(0, 4), d); chk("R6 rx stamp", d, 32'(e1));
    rdc(1, d); chk("R4 mb1 still empty", d, cw(1, 1, 8));
    send(29'h1234567, 1, 4'd2, 64'h0);
    rdc(1, d); chk("R4 second frame to mb1", d, cw(2, 1, 2));
    send(29'h1234567, 1, 4'd3, 64'h0);
    rdc(0, d); chk("R5 overrun on mb0", d, cw(2, 1, 5) | 32'h8);
    rdc(1, d); chk("R5 no overrun on mb1", d, cw(2, 1, 2));
    wr(ma(0, 0), cw(2, 1, 5));
    rdc(0, d); chk("R5 write clears overrun", d, cw(2, 1, 5));
    clear_all();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    setmb(3, 1, 0, 29'h123 << 18);
    send((29'h123 << 18) | 29'h5, 0, 4'd1, 64'h0);
    rdc(3, d); chk("R2 std compares top bits only", d, cw(2, 0, 1));
    setmb(4, 1, 1, 29'h4 << 18);
    send(29'h4 << 18, 0, 4'd1, 64'h0);
    rdc(4, d); chk("R2 IDE mismatch rejected", d, cw(1, 1, 8));
    wr(8'h80, 32'h1FFFFF00);
    setmb(2, 1, 1, 29'hA00);
    send(29'hB55, 1, 4'd1, 64'h0);
    rdc(2, d); chk("R2 care bit differs", d, cw(1, 1, 8));
    send(29'hA55, 1, 4'd1, 64'h0);
    rdc(2, d); chk("R2 don't-care bits", d, cw(2, 1, 1));
    clear_all();
    wr(8'h81, 32'h1FFFFF00);
    setmb(14, 1, 1, 29'h100); setmb(15, 1, 1, 29'h200);
    send(29'h1FF, 1, 4'd1, 64'h0);
    rdc(14, d); chk("R3 mb14 private mask", d, cw(2, 1, 1));
    send(29'h2AA, 1, 4'd1, 64'h0);
    rdc(15, d); chk("R3 mb15 exact under mask B", d, cw(1, 1, 8));
    wr(8'h82, 32'h1FFFFF00);
    send(29'h2AA, 1, 4'd1, 64'h0);
    rdc(15, d); chk("R3 mb15 own mask", d, cw(2, 1, 1));
    clear_all();
  endtask

  task automatic t_tx_index();
    logic [31:0] d;
    wr(8'h83, 32'd2);
    setmb(5, 4, 1, 29'h50); setmb(3, 4, 1, 29'h700); setmb(9, 4, 1, 29'h10);
    @(negedge clk); #1 chk("R7 tx_req", tx_req, 1); chk("R7 lowest index", tx_mb, 3);
    chk("R7 offered id", tx_id, 29'h700);
    ack();
    rdc(3, d); chk("R9 mb3 done", d[2:0], 3);
    rd(ma(3, 4), d); chk("R9 tx stamp", d, 32'(ets));
    @(negedge clk); #1 chk("R7 next index", tx_mb, 5);
    clear_all();
  endtask

  task automatic t_tx_id();
    wr(8'h83, 32'd0);
    setmb(9, 4, 0, 29'h1 << 18); setmb(2, 4, 1, 29'h800);
    setmb(7, 4, 1, 29'h50); setmb(5, 4, 1, 29'h50);
    @(negedge clk); #1 chk("R8 lowest id tie to lower index", tx_mb, 5);
    ack(); @(negedge clk); #1 chk("R8 tie partner", tx_mb, 7);
    ack(); @(negedge clk); #1 chk("R8 ext below aligned std", tx_mb, 2);
    ack(); @(negedge clk); #1 chk("R8 std last", tx_mb, 9);
    chk("R8 std ide", tx_ide, 0);
    ack(); @(negedge clk); #1 chk("R9 none pending", tx_req, 0);
    clear_all();
  endtask

  task automatic t_listen();
    logic [31:0] d;
    wr(8'h83, 32'd1);
    setmb(4, 4, 1, 29'h44);
    @(negedge clk); #1 chk("R10 no request", tx_req, 0);
    ack();
    rdc(4, d); chk("R10 ack ignored", d[2:0], 4);
    wr(8'h83, 32'd0);
    @(negedge clk); #1 chk("R10 request after leaving", tx_req, 1);
    clear_all();
  endtask

  task automatic t_lock();
    logic [31:0] d;
    setmb(6, 1, 1, 29'h66);
    send(29'h66, 1, 4'd1, 64'h0);
    rd(ma(6, 0), d); chk("R11 mb6 full", d, cw(2, 1, 1));
    wr(ma(6, 0), cw(1, 1, 8));
    send(29'h66, 1, 4'd2, 64'h0);
    rd(ma(6, 0), d); chk("R11 locked mailbox skipped", d, cw(1, 1, 8));
    rd(8'h84, d);
    send(29'h66, 1, 4'd2, 64'h0);
    rdc(6, d); chk("R11 accepted after unlock", d, cw(2, 1, 2));
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_accept(); t_mask(); t_tx_index(); t_tx_id(); t_listen(); t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule